// File: doc/BRIEF.md
# Configurable CSR Field Storage

This block holds one field of a control/status register. Software reaches it through a simple strobe port: an address-decoded write strobe with write data, and a read strobe that returns the field on a read-data bus in the same cycle. Hardware reaches it through a next-value input and an optional load enable of either polarity. Per-bit enable and mask vectors decide which bits a hardware load may change.

Parameters set the field's behaviour. They fix the width and the reset value, and they say whether software may write the field. They choose how hardware updates it: an active-high load, an active-low load, or no load at all. With no load the field is a plain wire from the hardware input. A parameter can also take the next value from an alternate input instead of the default one. Another makes the field self-clear in every cycle with no write. The self-clear option cannot be combined with the alternate next-value source, and elaboration stops if both are set.

When software and hardware write in the same cycle, hardware takes every bit it qualifies for. Software takes the remaining bits. The current value is always visible on a dedicated output for the surrounding logic.

Top module: `csr_field`

## Requirements
- R1: While reset is active, and on leaving it, a field with storage holds RESET_VALUE (0x55 by default, width 8).
- R2: In active-high load mode, the selected next value is loaded in a cycle where hwWe is 1 and shows on fieldValue after that clock edge. With hwWe at 0, and no software write, the value holds.
- R3: In active-low load mode, the selected next value is loaded in a cycle where hwWel is 0. hwWel at 1 blocks the load, and hwWe is ignored.
- R4: A hardware load changes bit k only when hwEnable[k] is 1 and hwMask[k] is 0. Every other bit keeps its value, or takes the software data if software writes in the same cycle.
- R5: When a software write and a hardware load happen in one cycle, the hardware value wins on the bits qualified by R4. Software data goes into the remaining bits.
- R6: With no load enable configured, fieldValue and the read data follow the selected next input in the same cycle, and software writes have no effect.
- R7: With software write access disabled, swWrStb and swWrData never change the field. Hardware loads still apply.
- R8: With NEXT_SRC_ALT set, altNext is the next-value source and hwNext has no effect. With NEXT_SRC_ALT clear, the roles are swapped.
- R9: swAcc is 1 exactly in each cycle where swRdStb is 1. In that cycle swRdData carries the current field value (the live input in wire mode). swRdData is 0 when no read is made.
- R10: With SINGLE_PULSE set, each bit not written by software or hardware in a cycle becomes 0 at that clock edge. This clearing has the lowest priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| swWrStb | input | 1 | Software write strobe (already address-decoded) |
| swWrData | input | WIDTH | Software write data |
| swRdStb | input | 1 | Software read strobe (already address-decoded) |
| swRdData | output | WIDTH | Read data, valid in the strobe cycle, 0 otherwise |
| hwNext | input | WIDTH | Default hardware next value |
| altNext | input | WIDTH | Alternate hardware next value |
| hwWe | input | 1 | Hardware load enable, active high |
| hwWel | input | 1 | Hardware load enable, active low |
| hwEnable | input | WIDTH | Per-bit hardware load enable |
| hwMask | input | WIDTH | Per-bit hardware load mask |
| fieldValue | output | WIDTH | Current field value |
| swAcc | output | 1 | Software read access strobe |

## Verification
The hardest case to reach is a cycle where a software write, a hardware load and partial enable/mask vectors all meet. In that cycle each bit of the result comes from a different source. The bench ties each control input to its own bit of a sweep counter, so every on/off pairing of load, write, inverted load and read occurs. The enable and mask vectors cycle through full, empty and mixed patterns at the same time. The two next-value inputs always carry different values, so a field that reads the wrong source gives a visible mismatch.

// File: rtl/csr_field_pkg.sv
package csr_field_pkg;

  // How hardware updates the field
  typedef enum logic [1:0] {
    HWWE_NONE = 2'd0,  // no load enable: field is a wire
    HWWE_HIGH = 2'd1,  // load when hwWe == 1
    HWWE_LOW  = 2'd2   // load when hwWel == 0
  } hwWeMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic swWr;     // qualified software write
    logic hwLoad;   // qualified hardware load
    logic idleClr;  // clear unwritten bits (single-pulse)
    logic rdAcc;    // software read access
  } fieldStrobes_t;

endpackage

// File: rtl/csr_field_ctrl.sv
module csr_field_ctrl
  import csr_field_pkg::*;
#(
  parameter hwWeMode_e WE_MODE      = HWWE_HIGH,
  parameter bit        SW_WRITABLE  = 1'b1,
  parameter bit        SINGLE_PULSE = 1'b0
) (
  input  logic          swWrStb,
  input  logic          swRdStb,
  input  logic          hwWe,
  input  logic          hwWel,
  output fieldStrobes_t strobes
);

  localparam bit HasStorage = (WE_MODE != HWWE_NONE);

  logic loadReq;

  always_comb begin
    unique case (WE_MODE)
      HWWE_HIGH: loadReq = hwWe;
      HWWE_LOW:  loadReq = ~hwWel;
      default:   loadReq = 1'b0;
    endcase
  end

  always_comb begin
    strobes.swWr    = HasStorage && SW_WRITABLE && swWrStb;
    strobes.hwLoad  = HasStorage && loadReq;
    strobes.idleClr = HasStorage && SINGLE_PULSE;
    strobes.rdAcc   = swRdStb;
  end

endmodule

// File: rtl/csr_field_datapath.sv
module csr_field_datapath
  import csr_field_pkg::*;
#(
  parameter int              WIDTH        = 8,
  parameter logic [WIDTH-1:0] RESET_VALUE = 8'h55,
  parameter hwWeMode_e       WE_MODE      = HWWE_HIGH,
  parameter bit              NEXT_SRC_ALT = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  fieldStrobes_t    strobes,
  input  logic [WIDTH-1:0] swWrData,
  input  logic [WIDTH-1:0] hwNext,
  input  logic [WIDTH-1:0] altNext,
  input  logic [WIDTH-1:0] hwEnable,
  input  logic [WIDTH-1:0] hwMask,
  output logic [WIDTH-1:0] fieldValue,
  output logic [WIDTH-1:0] swRdData
);

  localparam logic [WIDTH-1:0] AllZero = '0;

  logic [WIDTH-1:0] nextSel;

  // Next-value source selection
  generate
    if (NEXT_SRC_ALT) begin : gSrcAlt
      assign nextSel = altNext;
      logic unusedDefault;
      assign unusedDefault = ^hwNext;
    end else begin : gSrcDefault
      assign nextSel = hwNext;
      logic unusedAlt;
      assign unusedAlt = ^altNext;
    end
  endgenerate

  // Storage variant: flop with qualified loads, or plain wire
  generate
    if (WE_MODE == HWWE_NONE) begin : gWire
      assign fieldValue = nextSel;
      logic unusedWire;
      assign unusedWire = ^{swWrData, hwEnable, hwMask, strobes.swWr,
                            strobes.hwLoad, strobes.idleClr, clk, rstN};
    end else begin : gFlop
      logic [WIDTH-1:0] fieldQ;
      logic [WIDTH-1:0] fieldD;
      logic [WIDTH-1:0] hwBits;
      logic [WIDTH-1:0] baseVal;

      always_comb begin
        hwBits = {WIDTH{strobes.hwLoad}} & hwEnable & ~hwMask;
        if (strobes.swWr)
          baseVal = swWrData;
        else if (strobes.idleClr)
          baseVal = AllZero;
        else
          baseVal = fieldQ;
        fieldD = (nextSel & hwBits) | (baseVal & ~hwBits);
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) fieldQ <= RESET_VALUE;
        else       fieldQ <= fieldD;
      end

      assign fieldValue = fieldQ;
    end
  endgenerate

  assign swRdData = strobes.rdAcc ? fieldValue : AllZero;

endmodule

// File: rtl/csr_field.sv
module csr_field
  import csr_field_pkg::*;
#(
  parameter int               WIDTH        = 8,
  parameter logic [WIDTH-1:0] RESET_VALUE  = 8'h55,
  parameter hwWeMode_e        WE_MODE      = HWWE_HIGH,
  parameter bit               SW_WRITABLE  = 1'b1,
  parameter bit               NEXT_SRC_ALT = 1'b0,
  parameter bit               SINGLE_PULSE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swWrStb,
  input  logic [WIDTH-1:0] swWrData,
  input  logic             swRdStb,
  output logic [WIDTH-1:0] swRdData,
  input  logic [WIDTH-1:0] hwNext,
  input  logic [WIDTH-1:0] altNext,
  input  logic             hwWe,
  input  logic             hwWel,
  input  logic [WIDTH-1:0] hwEnable,
  input  logic [WIDTH-1:0] hwMask,
  output logic [WIDTH-1:0] fieldValue,
  output logic             swAcc
);

  // Self-clear and an alternate next source both override the next value
  generate
    if (SINGLE_PULSE && NEXT_SRC_ALT) begin : gBadCfg
      $error("csr_field: SINGLE_PULSE and NEXT_SRC_ALT are mutually exclusive");
    end
  endgenerate

  fieldStrobes_t strobes;

  csr_field_ctrl #(
    .WE_MODE     (WE_MODE),
    .SW_WRITABLE (SW_WRITABLE),
    .SINGLE_PULSE(SINGLE_PULSE)
  ) ctrl (
    .swWrStb(swWrStb),
    .swRdStb(swRdStb),
    .hwWe   (hwWe),
    .hwWel  (hwWel),
    .strobes(strobes)
  );

  csr_field_datapath #(
    .WIDTH       (WIDTH),
    .RESET_VALUE (RESET_VALUE),
    .WE_MODE     (WE_MODE),
    .NEXT_SRC_ALT(NEXT_SRC_ALT)
  ) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .swWrData  (swWrData),
    .hwNext    (hwNext),
    .altNext   (altNext),
    .hwEnable  (hwEnable),
    .hwMask    (hwMask),
    .fieldValue(fieldValue),
    .swRdData  (swRdData)
  );

  assign swAcc = strobes.rdAcc;

endmodule

// File: rtl/csr_field_chk.sv
module csr_field_chk
  import csr_field_pkg::*;
#(
  parameter int               WIDTH        = 8,
  parameter logic [WIDTH-1:0] RESET_VALUE  = 8'h55,
  parameter hwWeMode_e        WE_MODE      = HWWE_HIGH,
  parameter bit               SW_WRITABLE  = 1'b1,
  parameter bit               NEXT_SRC_ALT = 1'b0,
  parameter bit               SINGLE_PULSE = 1'b0
) (
  input logic             clk,
  input logic             rstN,
  input logic             swWrStb,
  input logic [WIDTH-1:0] swWrData,
  input logic             swRdStb,
  input logic [WIDTH-1:0] swRdData,
  input logic [WIDTH-1:0] hwNext,
  input logic [WIDTH-1:0] altNext,
  input logic             hwWe,
  input logic             hwWel,
  input logic [WIDTH-1:0] hwEnable,
  input logic [WIDTH-1:0] hwMask,
  input logic [WIDTH-1:0] fieldValue,
  input logic             swAcc
);

  localparam logic [WIDTH-1:0] Ones = '1;

  logic             portLoad;
  logic [WIDTH-1:0] srcNext;
  logic             unusedChk;

  assign portLoad  = (WE_MODE == HWWE_HIGH) ? hwWe :
                     (WE_MODE == HWWE_LOW)  ? !hwWel : 1'b0;
  assign srcNext   = NEXT_SRC_ALT ? altNext : hwNext;
  assign unusedChk = ^{swWrData, RESET_VALUE};

  AST_READ_RETURNS_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    swRdStb |-> (swAcc && swRdData == fieldValue)); // R9
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !swRdStb |-> (!swAcc && swRdData == '0)); // R9

  generate
    if (WE_MODE == HWWE_NONE) begin : gWireChk
      AST_WIRE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
        fieldValue == srcNext); // R6
    end else begin : gFlopChk
      AST_FULL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
        (portLoad && hwEnable == Ones && hwMask == '0) |=> fieldValue == $past(srcNext)); // R2
      AST_HW_OVER_SW: assert property (@(posedge clk) disable iff (!rstN)
        (portLoad && swWrStb && hwEnable == Ones && hwMask == '0) |=> fieldValue == $past(srcNext)); // R5
      AST_QUALIFIER_KEEP: assert property (@(posedge clk) disable iff (!rstN)
        (portLoad && !(SW_WRITABLE && swWrStb) && !SINGLE_PULSE)
          |=> ((fieldValue ^ $past(fieldValue)) & $past(~hwEnable | hwMask)) == '0); // R4
      AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        (!portLoad && !swWrStb && !SINGLE_PULSE) |=> $stable(fieldValue)); // R2
      AST_RO_IGNORES_SW: assert property (@(posedge clk) disable iff (!rstN)
        (!SW_WRITABLE && !portLoad && !SINGLE_PULSE) |=> $stable(fieldValue)); // R7
      AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
        (SINGLE_PULSE && !portLoad && !(SW_WRITABLE && swWrStb)) |=> fieldValue == '0); // R10
    end
  endgenerate

endmodule

bind csr_field csr_field_chk #(
  .WIDTH       (WIDTH),
  .RESET_VALUE (RESET_VALUE),
  .WE_MODE     (WE_MODE),
  .SW_WRITABLE (SW_WRITABLE),
  .NEXT_SRC_ALT(NEXT_SRC_ALT),
  .SINGLE_PULSE(SINGLE_PULSE)
) chk (
  .clk       (clk),
  .rstN      (rstN),
  .swWrStb   (swWrStb),
  .swWrData  (swWrData),
  .swRdStb   (swRdStb),
  .swRdData  (swRdData),
  .hwNext    (hwNext),
  .altNext   (altNext),
  .hwWe      (hwWe),
  .hwWel     (hwWel),
  .hwEnable  (hwEnable),
  .hwMask    (hwMask),
  .fieldValue(fieldValue),
  .swAcc     (swAcc)
);

// File: tb/csr_field_test.sv
`timescale 1ns/100ps
module csr_field_test;
  import csr_field_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       swWrStb = 1'b0;
  logic [7:0] swWrData = '0;
  logic       swRdStb = 1'b0;
  logic [7:0] hwNext = '0;
  logic [7:0] altNext = '0;
  logic       hwWe = 1'b0;
  logic       hwWel = 1'b1;
  logic [7:0] hwEnable = '0;
  logic [7:0] hwMask = '0;

  logic [7:0] valHi, valLow, valRo, valWire, valSp;
  logic [7:0] rdHi, rdLow, rdRo, rdWire, rdSp;
  logic       accHi, accLow, accRo, accWire, accSp;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  // Active-high, software read-write, default source
  csr_field uut (.clk(clk), .rstN(rstN), .swWrStb(swWrStb), .swWrData(swWrData),
    .swRdStb(swRdStb), .swRdData(rdHi), .hwNext(hwNext), .altNext(altNext),
    .hwWe(hwWe), .hwWel(hwWel), .hwEnable(hwEnable), .hwMask(hwMask),
    .fieldValue(valHi), .swAcc(accHi));

  // Active-low, alternate source
  csr_field #(.WE_MODE(HWWE_LOW), .NEXT_SRC_ALT(1'b1)) uutLow (.clk(clk), .rstN(rstN),
    .swWrStb(swWrStb), .swWrData(swWrData), .swRdStb(swRdStb), .swRdData(rdLow),
    .hwNext(hwNext), .altNext(altNext), .hwWe(hwWe), .hwWel(hwWel),
    .hwEnable(hwEnable), .hwMask(hwMask), .fieldValue(valLow), .swAcc(accLow));

  // Software read-only
  csr_field #(.SW_WRITABLE(1'b0)) uutRo (.clk(clk), .rstN(rstN),
    .swWrStb(swWrStb), .swWrData(swWrData), .swRdStb(swRdStb), .swRdData(rdRo),
    .hwNext(hwNext), .altNext(altNext), .hwWe(hwWe), .hwWel(hwWel),
    .hwEnable(hwEnable), .hwMask(hwMask), .fieldValue(valRo), .swAcc(accRo));

  // Wire mode
  csr_field #(.WE_MODE(HWWE_NONE), .SW_WRITABLE(1'b0)) uutWire (.clk(clk), .rstN(rstN),
    .swWrStb(swWrStb), .swWrData(swWrData), .swRdStb(swRdStb), .swRdData(rdWire),
    .hwNext(hwNext), .altNext(altNext), .hwWe(hwWe), .hwWel(hwWel),
    .hwEnable(hwEnable), .hwMask(hwMask), .fieldValue(valWire), .swAcc(accWire));

  // Single-pulse
  csr_field #(.SINGLE_PULSE(1'b1)) uutSp (.clk(clk), .rstN(rstN),
    .swWrStb(swWrStb), .swWrData(swWrData), .swRdStb(swRdStb), .swRdData(rdSp),
    .hwNext(hwNext), .altNext(altNext), .hwWe(hwWe), .hwWel(hwWel),
    .hwEnable(hwEnable), .hwMask(hwMask), .fieldValue(valSp), .swAcc(accSp));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected next value: qualified hardware bits, else software data,
  // else cleared (single-pulse) or held
  function automatic logic [7:0] model(input logic [7:0] cur, input logic load,
      input logic swOn, input logic [7:0] swd, input logic [7:0] src,
      input logic [7:0] en, input logic [7:0] msk, input logic sp);
    logic [7:0] hb, other;
    hb = load ? (en & ~msk) : 8'h00;
    other = swOn ? swd : (sp ? 8'h00 : cur);
    return (src & hb) | (other & ~hb);
  endfunction

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    logic [7:0] expHi, expLow, expRo, expSp;
    expHi = 8'h55; expLow = 8'h55; expRo = 8'h55; expSp = 8'h55;

    repeat (3) @(negedge clk);
    check("R1 reset high", valHi, 8'h55);
    check("R1 reset low", valLow, 8'h55);
    check("R1 reset ro", valRo, 8'h55);
    check("R1 reset pulse", valSp, 8'h55);
    rstN = 1'b1;

    for (int i = 0; i < 256; i++) begin
      logic [7:0] iv;
      iv = 8'(i);
      if (i > 0) @(negedge clk);
      // Results of the previous edge
      check("R2,R4,R5 high field", valHi, expHi);
      check("R3,R8 low/alt field", valLow, expLow);
      check("R7 read-only field", valRo, expRo);
      check("R10 pulse field", valSp, expSp);

      // Drive this cycle
      hwWe     = iv[0];
      swWrStb  = iv[1];
      hwWel    = iv[2];
      swRdStb  = iv[3];
      hwNext   = 8'(i * 37 + 5);
      altNext  = 8'(i * 53 + 11);
      swWrData = 8'(i * 91 + 3);
      case (iv[5:4])
        2'd0: begin hwEnable = 8'hFF;         hwMask = 8'h00; end
        2'd1: begin hwEnable = 8'(i * 13);    hwMask = 8'h00; end
        2'd2: begin hwEnable = 8'hFF;         hwMask = 8'(i * 29); end
        default: begin hwEnable = 8'(i * 13); hwMask = 8'(i * 29 + 1); end
      endcase
      #1;
      check("R6 wire value", valWire, hwNext);
      if (swRdStb) begin
        check("R9 acc high", {7'd0, accHi}, 8'h01);
        check("R9 read high", rdHi, expHi);
        check("R9 read low", rdLow, expLow);
        check("R6,R9 read wire", rdWire, hwNext);
      end else begin
        check("R9 no acc", {7'd0, accHi | accLow | accRo | accWire | accSp}, 8'h00);
        check("R9 idle data", rdHi | rdLow | rdRo | rdWire | rdSp, 8'h00);
      end

      expHi  = model(expHi,  hwWe,   swWrStb, swWrData, hwNext,  hwEnable, hwMask, 1'b0);
      expLow = model(expLow, !hwWel, swWrStb, swWrData, altNext, hwEnable, hwMask, 1'b0);
      expRo  = model(expRo,  hwWe,   1'b0,    swWrData, hwNext,  hwEnable, hwMask, 1'b0);
      expSp  = model(expSp,  hwWe,   swWrStb, swWrData, hwNext,  hwEnable, hwMask, 1'b1);
    end

    @(negedge clk);
    check("R2,R4,R5 high final", valHi, expHi);
    check("R3,R8 low final", valLow, expLow);
    check("R7 ro final", valRo, expRo);
    check("R10 pulse final", valSp, expSp);

    // Directed: same-cycle hw and sw, full qualifiers (R5)
    hwWe = 1'b1; swWrStb = 1'b1; hwWel = 1'b1; swRdStb = 1'b0;
    hwNext = 8'hA6; swWrData = 8'h3C; hwEnable = 8'hFF; hwMask = 8'h00;
    @(negedge clk);
    check("R5 hw wins", valHi, 8'hA6);
    // Directed: hwNext change must not reach alternate-source field (R8)
    hwWe = 1'b0; swWrStb = 1'b0; hwWel = 1'b0; altNext = 8'h21; hwNext = 8'hE7;
    @(negedge clk);
    check("R8 alt source", valLow, 8'h21);
    check("R2 hold without load", valHi, 8'hA6);

    // Reset again
    rstN = 1'b0;
    @(negedge clk);
    check("R1 re-reset high", valHi, 8'h55);
    check("R1 re-reset pulse", valSp, 8'h55);
    finishRun();
  end

endmodule